// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block is the configuration register file of a multi-function I/O controller. The host sees it as two adjacent byte addresses. Offset 0 is an index port and offset 1 is a data port. The host writes a register number to the index port and then reads or writes that register through the data port. The register file starts locked. The host opens it by writing a key byte twice in a row to the index port, and closes it again by writing an exit key byte to the same port.

Register numbers below 0x30 are global. They include a logical-device select at 0x07, a read-only chip identifier at 0x20/0x21, and writable control bytes from 0x22 to 0x2F. Register numbers from 0x30 upward reach a bank of registers that belongs to the logical device currently selected. Bit 0 of each device's first banked register is brought out as that device's enable. Two global control bits are also brought out: a floppy-function enable and an I2C pin-function select. The peripheral functions that use these outputs lie outside this block.

Top module: `keyed_cfg_window`

## Requirements
- R1: After reset the window is locked, the index is 0x00, and every writable register is 0x00, so `devEnable`, `floppyEn` and `i2cSel` are all 0.
- R2: The window opens (`unlocked`=1 after the clock edge) only after two consecutive index-port writes of 0x87.
- R3: While the window is locked, an index-port write of any value other than 0x87 that arrives after a single 0x87 returns the key sequence to its start, so a following single 0x87 does not open the window.
- R4: An index-port write of 0xAA while the window is open locks it after that clock edge. The stored registers keep their values.
- R5: While the window is locked, data-port writes change no register, and reads of either port return 0xFF.
- R6: While the window is open, offset 0 reads back the last index written, and offset 1 reads the register that the index addresses. Reads are combinational.
- R7: Registers 0x20 and 0x21 read 0xA2 and 0x35, the two bytes of identifier 0xA235 with high byte first. Writes to them are ignored.
- R8: Register 0x07 holds the selected device number (all 8 bits). Registers 0x30 to 0x3F are stored separately for each of the 16 devices, and the selected device's copy is the one read and written.
- R9: `devEnable[d]` equals bit 0 of register 0x30 of device d.
- R10: `floppyEn` equals bit 1 of global register 0x24, and `i2cSel` equals bit 1 of global register 0x2A.
- R11: Index values that name no register read 0x00 and ignore writes. These are 0x00 to 0x1F other than 0x07, values of 0x40 and above, and banked indices when the selected device number is 16 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 1 | Port select: 0 for index, 1 for data |
| ioWrite | input | 1 | Write strobe, sampled on the clock edge |
| ioRead | input | 1 | Read strobe |
| ioWData | input | 8 | Write data byte |
| ioRData | output | 8 | Read data byte, combinational |
| unlocked | output | 1 | The window is open |
| devEnable | output | 16 | Enable bit of each logical device |
| floppyEn | output | 1 | Floppy function enable |
| i2cSel | output | 1 | I2C pin function select |

## Verification
The assertions check on every cycle the following rules:
- the window opens only on the edge of a second 0x87 key write;
- the exit key always closes the window;
- a locked window reads 0xFF;
- device-select, global and enable state does not change while the window is locked;
- the device enables move only after a write to index 0x30.

Only the bench scenarios can show the rest:
- a broken key sequence has to restart from the beginning;
- the banked registers of each device are isolated from one another;
- the identifier bytes hold their values;
- unnamed indices read zero;
- values survive being locked and unlocked again.

The bench shows these by comparing all outputs on every clock against a behavioural model.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

  typedef enum logic [1:0] {
    KEY_LOCKED,
    KEY_HALF,
    KEY_OPEN
  } keyState_t;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic       unlocked;
    logic       dataWr;
    logic       hitSel;
    logic       hitGlobal;
    logic       hitBank;
    logic [7:0] index;
  } cfgStrobe_t;

endpackage

// File: rtl/cfg_key_ctrl.sv
module cfg_key_ctrl
  import cfg_window_pkg::*;
#(
  parameter logic [7:0] KEY_ENTER   = 8'h87,
  parameter logic [7:0] KEY_EXIT    = 8'hAA,
  parameter logic [7:0] SEL_INDEX   = 8'h07,
  parameter logic [7:0] GLOBAL_BASE = 8'h20,
  parameter logic [7:0] BANK_BASE   = 8'h30,
  parameter int         BANK_REGS   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioAddr,
  input  logic       ioWrite,
  input  logic [7:0] ioWData,
  output cfgStrobe_t strobe
);

  localparam logic [8:0] BANK_END = 9'(BANK_BASE) + 9'(BANK_REGS);

  keyState_t  keyState;
  logic [7:0] indexReg;
  logic       idxWr;
  logic       isOpen;

  assign idxWr  = ioWrite && !ioAddr;
  assign isOpen = (keyState == KEY_OPEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KEY_LOCKED;
      indexReg <= 8'h00;
    end else if (idxWr) begin
      unique case (keyState)
        KEY_LOCKED: keyState <= (ioWData == KEY_ENTER) ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   keyState <= (ioWData == KEY_ENTER) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN: begin
          if (ioWData == KEY_EXIT) keyState <= KEY_LOCKED;
          else                     indexReg <= ioWData;
        end
        default:    keyState <= KEY_LOCKED;
      endcase
    end
  end

  always_comb begin
    strobe.unlocked  = isOpen;
    strobe.dataWr    = isOpen && ioWrite && ioAddr;
    strobe.index     = indexReg;
    strobe.hitSel    = (indexReg == SEL_INDEX);
    strobe.hitGlobal = (indexReg >= GLOBAL_BASE) && (indexReg < BANK_BASE);
    strobe.hitBank   = (indexReg >= BANK_BASE) && ({1'b0, indexReg} < BANK_END);
  end

  // R2: opening only follows a key write on the previous edge
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && !$past(isOpen)) |-> $past(idxWr && ioWData == KEY_ENTER));

  // R4: exit key always closes the window
  a_r4_exit_locks: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && idxWr && ioWData == KEY_EXIT) |=> !isOpen);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_window_pkg::*;
#(
  parameter int          NUM_DEV     = 16,
  parameter int          BANK_REGS   = 16,
  parameter logic [7:0]  GLOBAL_BASE = 8'h20,
  parameter logic [7:0]  BANK_BASE   = 8'h30,
  parameter logic [15:0] CHIP_ID     = 16'hA235,
  parameter logic [7:0]  FDC_REG     = 8'h24,
  parameter int          FDC_BIT     = 1,
  parameter logic [7:0]  I2C_REG     = 8'h2A,
  parameter int          I2C_BIT     = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic               ioAddr,
  input  logic               ioRead,
  input  logic [7:0]         ioWData,
  output logic [7:0]         ioRData,
  output logic [NUM_DEV-1:0] devEnable,
  output logic               floppyEn,
  output logic               i2cSel
);

  localparam int GLOBAL_REGS = int'(BANK_BASE) - int'(GLOBAL_BASE);
  localparam int GW          = $clog2(GLOBAL_REGS);
  localparam int BW          = $clog2(BANK_REGS);
  localparam int DW          = $clog2(NUM_DEV);
  localparam int FDC_SLOT    = int'(FDC_REG) - int'(GLOBAL_BASE);
  localparam int I2C_SLOT    = int'(I2C_REG) - int'(GLOBAL_BASE);
  localparam int ID_SLOTS    = 2;

  logic [7:0]    devSel;
  logic [7:0]    globMem [GLOBAL_REGS];
  logic [7:0]    bankMem [NUM_DEV][BANK_REGS];
  logic [GW-1:0] gOff;
  logic [BW-1:0] bOff;
  logic [DW-1:0] devIdx;
  logic          devValid;
  logic [7:0]    regData;

  assign gOff     = GW'(strobe.index - GLOBAL_BASE);
  assign bOff     = BW'(strobe.index - BANK_BASE);
  assign devIdx   = DW'(devSel);
  assign devValid = int'(devSel) < NUM_DEV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               devSel <= 8'h00;
    else if (strobe.dataWr && strobe.hitSel) devSel <= ioWData;
  end

  // Global bytes: ID slots are constants, the rest are writable
  for (genvar g = 0; g < GLOBAL_REGS; g++) begin : g_glob
    if (g < ID_SLOTS) begin : g_id
      assign globMem[g] = (g == 0) ? CHIP_ID[15:8] : CHIP_ID[7:0];
    end else begin : g_rw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) globMem[g] <= 8'h00;
        else if (strobe.dataWr && strobe.hitGlobal && gOff == GW'(g))
          globMem[g] <= ioWData;
      end
    end
  end

  // Per-device banked bytes
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < BANK_REGS; r++) bankMem[d][r] <= 8'h00;
      end else if (strobe.dataWr && strobe.hitBank && devValid && devIdx == DW'(d)) begin
        bankMem[d][bOff] <= ioWData;
      end
    end
    assign devEnable[d] = bankMem[d][0][0];
  end

  assign floppyEn = globMem[FDC_SLOT][FDC_BIT];
  assign i2cSel   = globMem[I2C_SLOT][I2C_BIT];

  always_comb begin
    regData = 8'h00;
    if (strobe.hitSel)                   regData = devSel;
    else if (strobe.hitGlobal)           regData = globMem[gOff];
    else if (strobe.hitBank && devValid) regData = bankMem[devIdx][bOff];
    if (!strobe.unlocked)                ioRData = 8'hFF;
    else if (ioAddr)                     ioRData = regData;
    else                                 ioRData = strobe.index;
  end

  // R5: locked window reads all ones
  a_r5_locked_reads_ff: assert property (@(posedge clk) disable iff (!rstN)
    (ioRead && !strobe.unlocked) |-> ioRData == 8'hFF);

  // R5: state is frozen while locked
  a_r5_locked_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.unlocked |=> ($stable(devSel) && $stable(floppyEn) && $stable(i2cSel)
                          && $stable(devEnable)));

  // R9: enables move only after a write to the first banked register
  a_r9_enable_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devEnable) |-> $past(strobe.dataWr && strobe.hitBank && bOff == '0));

endmodule

// File: rtl/keyed_cfg_window.sv
module keyed_cfg_window
  import cfg_window_pkg::*;
#(
  parameter int          NUM_DEV   = 16,
  parameter int          BANK_REGS = 16,
  parameter logic [15:0] CHIP_ID   = 16'hA235
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioAddr,
  input  logic               ioWrite,
  input  logic               ioRead,
  input  logic [7:0]         ioWData,
  output logic [7:0]         ioRData,
  output logic               unlocked,
  output logic [NUM_DEV-1:0] devEnable,
  output logic               floppyEn,
  output logic               i2cSel
);

  cfgStrobe_t strobe;

  cfg_key_ctrl #(
    .BANK_REGS (BANK_REGS)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ioAddr  (ioAddr),
    .ioWrite (ioWrite),
    .ioWData (ioWData),
    .strobe  (strobe)
  );

  cfg_reg_bank #(
    .NUM_DEV   (NUM_DEV),
    .BANK_REGS (BANK_REGS),
    .CHIP_ID   (CHIP_ID)
  ) i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ioAddr    (ioAddr),
    .ioRead    (ioRead),
    .ioWData   (ioWData),
    .ioRData   (ioRData),
    .devEnable (devEnable),
    .floppyEn  (floppyEn),
    .i2cSel    (i2cSel)
  );

  assign unlocked = strobe.unlocked;

endmodule

// File: tb/test_keyed_cfg_window.sv
module test_keyed_cfg_window;

  localparam int NDEV = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            ioAddr = 1'b0;
  logic            ioWrite = 1'b0;
  logic            ioRead = 1'b0;
  logic [7:0]      ioWData = 8'h00;
  logic [7:0]      ioRData;
  logic            unlocked;
  logic [NDEV-1:0] devEnable;
  logic            floppyEn;
  logic            i2cSel;

  int total = 0;
  int failed = 0;
  bit done = 0;

  // behavioural reference state
  int mState;
  int mIdx;
  int mSel;
  int mGlob[16];
  int mBank[NDEV][16];

  always #2.5 clk = ~clk;

  keyed_cfg_window i_keyed_cfg_window (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrite(ioWrite), .ioRead(ioRead),
    .ioWData(ioWData), .ioRData(ioRData), .unlocked(unlocked),
    .devEnable(devEnable), .floppyEn(floppyEn), .i2cSel(i2cSel)
  );

  function automatic int modelRead(bit a);
    if (mState != 2) return 8'hFF;
    if (!a) return mIdx;
    if (mIdx == 8'h07) return mSel;
    if (mIdx == 8'h20) return 8'hA2;
    if (mIdx == 8'h21) return 8'h35;
    if (mIdx >= 8'h22 && mIdx < 8'h30) return mGlob[mIdx - 8'h20];
    if (mIdx >= 8'h30 && mIdx < 8'h40 && mSel < NDEV) return mBank[mSel][mIdx - 8'h30];
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mIdx = 0; mSel = 0;
      for (int i = 0; i < 16; i++) mGlob[i] = 0;
      for (int d = 0; d < NDEV; d++) for (int r = 0; r < 16; r++) mBank[d][r] = 0;
    end else if (ioWrite) begin
      if (!ioAddr) begin
        if (mState == 2) begin
          if (ioWData == 8'hAA) mState = 0; else mIdx = ioWData;
        end else if (ioWData == 8'h87) mState = mState + 1;
        else mState = 0;
      end else if (mState == 2) begin
        if (mIdx == 8'h07) mSel = ioWData;
        else if (mIdx >= 8'h22 && mIdx < 8'h30) mGlob[mIdx - 8'h20] = ioWData;
        else if (mIdx >= 8'h30 && mIdx < 8'h40 && mSel < NDEV) mBank[mSel][mIdx - 8'h30] = ioWData;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    int en = 0;
    for (int d = 0; d < NDEV; d++) en |= (mBank[d][0] & 1) << d;
    check(tag, "rdata", int'(ioRData), modelRead(ioAddr));
    check(tag, "unlocked", int'(unlocked), int'(mState == 2));
    check("R9", "devEnable", int'(devEnable), en);
    check("R10", "floppyEn", int'(floppyEn), (mGlob[4] >> 1) & 1);
    check("R10", "i2cSel", int'(i2cSel), (mGlob[10] >> 1) & 1);
  endtask

  task automatic step(string tag, bit a, bit w, bit r, int d);
    @(negedge clk);
    ioAddr = a; ioWrite = w; ioRead = r; ioWData = 8'(d);
    #1 compareAll(tag);
  endtask

  task automatic idxW(string tag, int v);  step(tag, 0, 1, 0, v); endtask
  task automatic datW(string tag, int v);  step(tag, 1, 1, 0, v); endtask
  task automatic datR(string tag);         step(tag, 1, 0, 1, 0); endtask
  task automatic idxR(string tag);         step(tag, 0, 0, 1, 0); endtask
  task automatic regW(string tag, int i, int v); idxW(tag, i); datW(tag, v); datR(tag); endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1 reset state
    idxR("R1"); datR("R1");
    // R5 locked: write ignored, reads FF
    datW("R5", 8'h55); datR("R5"); idxR("R5");
    // R3 broken sequence
    idxW("R3", 8'h87); idxW("R3", 8'h11); idxW("R3", 8'h87); idxR("R3");
    idxW("R3", 8'h44); idxR("R3");
    // R2 open with two keys
    idxW("R2", 8'h87); idxR("R2"); idxW("R2", 8'h87); idxR("R2");
    // R6 index readback
    idxW("R6", 8'h2C); idxR("R6"); datR("R6");
    // R7 ID bytes, writes ignored
    regW("R7", 8'h20, 8'h00); regW("R7", 8'h21, 8'hFF);
    // R10 control bits
    regW("R10", 8'h24, 8'h02); regW("R10", 8'h2A, 8'hFD); regW("R10", 8'h2A, 8'hFF);
    // R8 banking
    regW("R8", 8'h07, 3); regW("R8", 8'h30, 8'h01); regW("R8", 8'h35, 8'hA5);
    regW("R8", 8'h07, 5); regW("R8", 8'h30, 8'h80); idxW("R8", 8'h35); datR("R8");
    regW("R8", 8'h3F, 8'h3C);
    regW("R8", 8'h07, 3); idxW("R8", 8'h35); datR("R8");
    // R9 enables of every device
    for (int d = 0; d < NDEV; d++) begin
      regW("R9", 8'h07, d); regW("R9", 8'h30, (d % 3 == 0) ? 8'h01 : 8'hFE);
    end
    // R11 unnamed indices
    regW("R11", 8'h10, 8'h77); regW("R11", 8'h40, 8'h77); regW("R11", 8'hFF, 8'h77);
    regW("R11", 8'h07, 8'h20); regW("R11", 8'h30, 8'h77); regW("R8", 8'h07, 8'h20);
    // R4 exit, then locked writes ignored, values retained
    idxW("R4", 8'hAA); idxR("R4");
    datW("R5", 8'h00); datR("R5");
    idxW("R4", 8'h87); idxW("R4", 8'h87);
    regW("R4", 8'h07, 0); idxW("R4", 8'h30); datR("R4"); idxW("R4", 8'h24); datR("R4");
    step("R6", 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule